// File: doc/BRIEF.md
# Configurable Write-Through Two-Way Cache

This block is a small first-level cache that sits between a processor and an external memory bus. It holds 1 KB in 64 sets of two ways, with 8-byte lines. Each processor request carries a byte address, a store strobe and a flag that marks an instruction fetch. A run-time allocation mode says which request types are cached: instruction fetches only, data accesses only, or both. A request of a type that is not cached bypasses the cache and goes to memory.

A cacheable read that hits completes in the cycle it is presented and causes no bus traffic. A read that misses, or a read that bypasses the cache, fetches the whole line over a request/acknowledge memory port. A cacheable miss installs the line in the chosen way before the data goes back to the processor.

Every store is written through to memory. The store is posted into a one-line (64-bit) buffer, so the processor goes on while memory completes the write. A store hit also updates the cached copy, and a store miss does not allocate a line. A flush pulse, or any change of the mode input, drops every line at once.

Top module: `cache_wt_l1`

## Requirements
- R1: The cache holds 64 sets of two ways with 8-byte lines. Address bits [2:0] select a byte and do not affect lookup, bits [8:3] select the set, and the bits above them form the tag. A third distinct line that maps to a full set displaces one of the two resident lines, and one line never matches in both ways.
- R2: A cacheable read of a resident line asserts cpu_ready in the same cycle, returns the line's latest stored value on cpu_rdata, and starts no memory read.
- R3: The mode input is encoded as follows: 2'b00 caches instruction requests only (cpu_instr=1), 2'b01 caches data requests only (cpu_instr=0), and 2'b10 and 2'b11 cache both. A read of a type that is not cached always goes to memory and installs nothing.
- R4: Every accepted store appears exactly once on the memory port as a write (mem_we=1), in program order, with the line-aligned address and its data. A store to a resident line updates the cached copy whatever the request type, so a later hit returns the new value.
- R5: The store buffer holds one store. A store is accepted in the cycle it is presented when the buffer is empty. While the buffer is occupied, a store stalls until the cycle after the memory acknowledges the buffered write.
- R6: A read miss starts no memory read while a store is waiting in the buffer.
- R7: A store to a line that is not resident installs nothing (no-write-allocate), so the next read of that line misses.
- R8: A fill uses an invalid way of the set when one exists. Otherwise it replaces the least recently used way. Read hits, store hits and fills all count as uses.
- R9: A miss reads the line-aligned address from memory. cpu_ready rises in the cycle after the read acknowledge and carries the fetched data. A cacheable miss has already written the line into the cache by then.
- R10: A one-cycle flush pulse, or a change of the mode input, invalidates every line at the next clock edge, so the following read misses.
- R11: After reset the block is idle, with cpu_ready and mem_req low. A memory request keeps its address and direction stable until its acknowledge is sampled. No memory read occurs without a processor read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 2 | Allocation mode: 00 instructions, 01 data, 1x both |
| flush | input | 1 | Invalidate all lines at the next edge |
| cpu_req | input | 1 | Processor request valid, held until cpu_ready |
| cpu_we | input | 1 | 1 for a store, 0 for a read |
| cpu_instr | input | 1 | 1 for an instruction fetch, 0 for a data access |
| cpu_addr | input | ADDR_W | Byte address |
| cpu_wdata | input | 64 | Store data (whole line) |
| cpu_ready | output | 1 | Request completes in this cycle |
| cpu_rdata | output | 64 | Read data, valid with cpu_ready on a read |
| mem_req | output | 1 | Memory request, held until mem_ack |
| mem_we | output | 1 | 1 for a memory write, 0 for a line read |
| mem_addr | output | ADDR_W | Line-aligned memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | One-cycle acknowledge of the current request |
| mem_rdata | input | 64 | Line data, valid with mem_ack on a read |

## Verification
The assertions assume a well-behaved processor. It holds a request with a stable address, type and data until cpu_ready. It changes mode or pulses flush only in a cycle with no request outstanding. The memory only acknowledges a request that is present, and pulses mem_ack for one cycle. The bench keeps to these rules: it drives each request until it completes, applies mode changes and flushes in separate idle cycles, and answers with a responder that waits one to three cycles, acks once and then drops the acknowledge.

// File: rtl/cwt_pkg.sv
package cwt_pkg;

  typedef enum logic [1:0] {
    ALLOC_INSTR = 2'b00,
    ALLOC_DATA  = 2'b01,
    ALLOC_BOTH  = 2'b10,
    ALLOC_BOTH2 = 2'b11
  } alloc_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_DONE = 2'd2
  } ctl_state_e;

  // R3: may a request of this type be held in the cache under this mode
  function automatic logic may_alloc(input logic [1:0] mode, input logic is_instr);
    return mode[1] | (mode[0] ? ~is_instr : is_instr);
  endfunction

endpackage

// File: rtl/cwt_tag_store.sv
module cwt_tag_store #(
  parameter int SETS  = 64,
  parameter int TAG_W = 7,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] idx,
  input  logic [TAG_W-1:0] tag,
  output logic [1:0]       hit_vec,
  output logic             victim,
  input  logic             inval_all,
  input  logic             touch_en,
  input  logic             touch_way,
  input  logic             fill_en,
  input  logic             fill_way
);

  logic [1:0]      way_valid;
  logic [SETS-1:0] lru_q;  // per set: way to replace next

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [SETS-1:0]  vld_q;
    logic [TAG_W-1:0] tag_q [SETS];

    assign way_valid[w] = vld_q[idx];
    assign hit_vec[w]   = vld_q[idx] && (tag_q[idx] == tag);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            vld_q      <= '0;
      else if (inval_all)                    vld_q      <= '0;
      else if (fill_en && fill_way == 1'(w)) vld_q[idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
      if (fill_en && fill_way == 1'(w)) tag_q[idx] <= tag;
    end
  end

  // invalid way first, then the least recently used one
  always_comb begin
    if (!way_valid[0])      victim = 1'b0;
    else if (!way_valid[1]) victim = 1'b1;
    else                    victim = lru_q[idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         lru_q      <= '0;
    else if (inval_all) lru_q      <= '0;
    else if (fill_en)   lru_q[idx] <= ~fill_way;
    else if (touch_en)  lru_q[idx] <= ~touch_way;
  end

endmodule

// File: rtl/cwt_data_store.sv
module cwt_data_store #(
  parameter int SETS   = 64,
  parameter int DATA_W = 64,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic                 clk,
  input  logic [IDX_W-1:0]     idx,
  input  logic                 we,
  input  logic                 way,
  input  logic [DATA_W-1:0]    wdata,
  output logic [1:0][DATA_W-1:0] rdata
);

  for (genvar w = 0; w < 2; w++) begin : g_way
    logic [DATA_W-1:0] line_q [SETS];

    always_ff @(posedge clk) begin
      if (we && way == 1'(w)) line_q[idx] <= wdata;
    end

    assign rdata[w] = line_q[idx];
  end

endmodule

// File: rtl/cwt_post_buf.sv
module cwt_post_buf #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic [DATA_W-1:0] data_in,
  input  logic              retire,
  output logic              full,
  output logic [ADDR_W-1:0] addr_out,
  output logic [DATA_W-1:0] data_out
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      full <= 1'b0;
    else if (load)   full <= 1'b1;
    else if (retire) full <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (load) begin
      addr_out <= addr_in;
      data_out <= data_in;
    end
  end

endmodule

// File: rtl/cache_wt_l1.sv
module cache_wt_l1
  import cwt_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int LINE_BYTES  = 8,
  parameter int CACHE_BYTES = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              flush,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic              cpu_instr,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [LINE_BYTES*8-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [LINE_BYTES*8-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [LINE_BYTES*8-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [LINE_BYTES*8-1:0] mem_rdata
);

  localparam int DATA_W = LINE_BYTES * 8;
  localparam int WAYS   = 2;
  localparam int SETS   = CACHE_BYTES / (LINE_BYTES * WAYS);
  localparam int OFF_W  = $clog2(LINE_BYTES);
  localparam int IDX_W  = $clog2(SETS);
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;

  function automatic logic [IDX_W-1:0] set_of(input logic [ADDR_W-1:0] a);
    return a[OFF_W +: IDX_W];
  endfunction

  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1 -: TAG_W];
  endfunction

  function automatic logic [ADDR_W-1:0] line_base(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  endfunction

  // ---------------- named internal events ----------------
  ctl_state_e          state_q, state_d;
  logic [1:0]          mode_q;
  logic [DATA_W-1:0]   fill_q;
  logic [1:0]          hit_vec;
  logic                victim;
  logic [1:0][DATA_W-1:0] way_data;
  logic                wb_full;
  logic [ADDR_W-1:0]   wb_addr;
  logic [DATA_W-1:0]   wb_data;

  logic alloc_ok, rd_lookup, rd_hit, miss_start, wr_acc, wr_hit;
  logic fill_done, fill_en, touch_en, inval_all, store_we;
  logic unused_offset;

  assign unused_offset = ^cpu_addr[OFF_W-1:0];

  assign inval_all  = flush | (mode != mode_q);
  assign alloc_ok   = may_alloc(mode, cpu_instr);
  assign rd_lookup  = cpu_req && !cpu_we && (state_q == ST_IDLE);
  assign rd_hit     = rd_lookup && alloc_ok && (|hit_vec);
  assign miss_start = rd_lookup && !rd_hit && !wb_full;
  assign wr_acc     = cpu_req && cpu_we && (state_q == ST_IDLE) && !wb_full;
  assign wr_hit     = wr_acc && (|hit_vec);
  assign fill_done  = (state_q == ST_FILL) && mem_ack;
  assign fill_en    = fill_done && alloc_ok && !inval_all;
  assign touch_en   = rd_hit | wr_hit;
  assign store_we   = wr_hit | fill_en;

  // ---------------- storage ----------------
  cwt_tag_store #(.SETS(SETS), .TAG_W(TAG_W)) u_tags (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (set_of(cpu_addr)),
    .tag       (tag_of(cpu_addr)),
    .hit_vec   (hit_vec),
    .victim    (victim),
    .inval_all (inval_all),
    .touch_en  (touch_en),
    .touch_way (hit_vec[1]),
    .fill_en   (fill_en),
    .fill_way  (victim)
  );

  cwt_data_store #(.SETS(SETS), .DATA_W(DATA_W)) u_lines (
    .clk   (clk),
    .idx   (set_of(cpu_addr)),
    .we    (store_we),
    .way   (fill_en ? victim : hit_vec[1]),
    .wdata (fill_en ? mem_rdata : cpu_wdata),
    .rdata (way_data)
  );

  cwt_post_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wbuf (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (wr_acc),
    .addr_in  (line_base(cpu_addr)),
    .data_in  (cpu_wdata),
    .retire   (wb_full && mem_ack),
    .full     (wb_full),
    .addr_out (wb_addr),
    .data_out (wb_data)
  );

  // ---------------- control ----------------
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (miss_start) state_d = ST_FILL;
      ST_FILL: if (mem_ack)    state_d = ST_DONE;
      ST_DONE:                 state_d = ST_IDLE;
      default:                 state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= ALLOC_BOTH;
    end else begin
      state_q <= state_d;
      mode_q  <= mode;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_done) fill_q <= mem_rdata;
  end

  // ---------------- outputs ----------------
  assign cpu_ready = rd_hit | wr_acc | (state_q == ST_DONE);
  assign cpu_rdata = (state_q == ST_DONE) ? fill_q : way_data[hit_vec[1]];

  assign mem_req   = wb_full | (state_q == ST_FILL);
  assign mem_we    = wb_full;
  assign mem_addr  = wb_full ? wb_addr : line_base(cpu_addr);
  assign mem_wdata = wb_data;

endmodule

// File: rtl/cwt_chk.sv
module cwt_chk #(
  parameter int AW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cpu_req,
  input logic          cpu_we,
  input logic          cpu_ready,
  input logic          mem_req,
  input logic          mem_we,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [1:0]    hit_vec,
  input logic          rd_hit,
  input logic          wr_acc,
  input logic          inval_all
);

  assert_line_unique_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));

  assert_hit_no_bus_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_hit |-> !(mem_req && !mem_we));

  assert_store_forwarded_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_acc |=> (mem_req && mem_we));

  assert_stall_while_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we && !mem_ack) |=> !(cpu_req && cpu_we && cpu_ready));

  assert_read_after_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && !mem_we) |-> $past(!(mem_req && mem_we)));

  assert_miss_after_fill_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_req && !cpu_we && cpu_ready && !rd_hit) |-> $past(mem_req && !mem_we && mem_ack));

  assert_inval_drops_R10: assert property (@(posedge clk) disable iff (!rst_n)
    inval_all |=> !rd_hit);

  assert_req_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_we) && $stable(mem_addr)));

endmodule

bind cache_wt_l1 cwt_chk #(.AW(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cpu_req   (cpu_req),
  .cpu_we    (cpu_we),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_ack   (mem_ack),
  .mem_addr  (mem_addr),
  .hit_vec   (hit_vec),
  .rd_hit    (rd_hit),
  .wr_acc    (wr_acc),
  .inval_all (inval_all)
);

// File: tb/cache_wt_l1_tb.sv
module cache_wt_l1_tb;
  localparam int AW    = 16;
  localparam int NSETS = 64;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic [1:0]    mode = 2'b10;
  logic          flush = 1'b0;
  logic          cpu_req = 1'b0, cpu_we = 1'b0, cpu_instr = 1'b0;
  logic [AW-1:0] cpu_addr = '0;
  logic [63:0]   cpu_wdata = '0;
  logic          cpu_ready;
  logic [63:0]   cpu_rdata;
  logic          mem_req, mem_we;
  logic [AW-1:0] mem_addr;
  logic [63:0]   mem_wdata;
  logic          mem_ack = 1'b0;
  logic [63:0]   mem_rdata = '0;

  cache_wt_l1 #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .flush(flush),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_instr(cpu_instr), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;

  function automatic void cmp(input string tag, input string what,
                              input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, got, exp);
    end
  endfunction

  // ---------------- memory responder ----------------
  int lat = 1, wait_cnt = 0;
  logic [63:0] mem_store [int];

  function automatic logic [63:0] seed_word(input int ln);
    return {32'(ln) * 32'h9E37_79B1, ~32'(ln)};
  endfunction

  always @(negedge clk) begin
    int ln;
    if (mem_ack) begin
      mem_ack <= 1'b0;
      wait_cnt = 0;
    end else if (mem_req) begin
      wait_cnt++;
      if (wait_cnt >= lat) begin
        ln = int'(mem_addr) / 8;
        if (mem_we) mem_store[ln] = mem_wdata;
        else mem_rdata <= mem_store.exists(ln) ? mem_store[ln] : seed_word(ln);
        mem_ack <= 1'b1;
      end
    end
  end

  // ---------------- behavioural reference ----------------
  typedef struct { int line; logic [63:0] d; } wr_t;
  int          res_q[$];      // resident lines, most recent first
  logic [63:0] latest [int];  // value each line must read back
  wr_t         wq[$];         // stores not yet seen on the bus
  bit          wb_pend = 0;
  bit          rd_ack_seen = 0;
  logic [1:0]  mdl_mode = 2'b10;

  function automatic bit kind_cached(input logic [1:0] m, input bit ins);
    case (m)
      2'b00:   return ins;
      2'b01:   return !ins;
      default: return 1'b1;
    endcase
  endfunction

  function automatic bit resident(input int ln);
    foreach (res_q[i]) if (res_q[i] == ln) return 1'b1;
    return 1'b0;
  endfunction

  function automatic void promote(input int ln);
    int same = 0;
    for (int i = 0; i < res_q.size(); i++)
      if (res_q[i] == ln) begin res_q.delete(i); break; end
    res_q.push_front(ln);
    for (int i = 0; i < res_q.size(); i++)
      if (res_q[i] % NSETS == ln % NSETS) begin
        same++;
        if (same > 2) begin res_q.delete(i); break; end
      end
  endfunction

  function automatic logic [63:0] value_of(input int ln);
    return latest.exists(ln) ? latest[ln] : seed_word(ln);
  endfunction

  task automatic watch_bus(input bit reading, input int ln, input string tag);
    if (mem_req && !mem_we) begin
      cmp("R6", "read while store pending", 64'(wb_pend), 64'(0));
      if (reading) cmp(tag, "read address", 64'(mem_addr), 64'(ln * 8));
      else cmp(tag, "unexpected memory read", 64'(1), 64'(0));
    end
    if (mem_ack && mem_we) begin
      if (wq.size() == 0) cmp("R4", "extra memory write", 64'(1), 64'(0));
      else begin
        cmp("R4", "write address", 64'(mem_addr), 64'(wq[0].line * 8));
        cmp("R4", "write data", mem_wdata, wq[0].d);
        void'(wq.pop_front());
      end
      wb_pend = 0;
    end
    if (mem_ack && !mem_we) rd_ack_seen = 1;
  endtask

  task automatic do_op(input string tag, input bit we, input bit ins,
                       input logic [AW-1:0] a, input logic [63:0] wd);
    int ln = int'(a) / 8;
    bit cached = kind_cached(mdl_mode, ins);
    bit exp_hit = !we && cached && resident(ln);
    bit got, exp_r;
    rd_ack_seen = 0;
    @(negedge clk);
    cpu_req = 1; cpu_we = we; cpu_instr = ins; cpu_addr = a; cpu_wdata = wd;
    mode = mdl_mode; flush = 0;
    forever begin
      #1;
      exp_r = we ? !wb_pend : (exp_hit ? 1'b1 : rd_ack_seen);
      cmp(tag, "cpu_ready", 64'(cpu_ready), 64'(exp_r));
      if (!we && cpu_ready) cmp(tag, "cpu_rdata", cpu_rdata, value_of(ln));
      watch_bus(!we && !exp_hit, ln, tag);
      got = cpu_ready;
      @(posedge clk);
      if (got) begin
        if (we) begin
          wb_pend = 1;
          wq.push_back('{ln, wd});
          latest[ln] = wd;
          if (resident(ln)) promote(ln);
        end else if (cached) promote(ln);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle_cycle(input logic [1:0] m, input bit fl);
    @(negedge clk);
    cpu_req = 0; mode = m; flush = fl;
    #1;
    cmp("R11", "cpu_ready when idle", 64'(cpu_ready), 64'(0));
    watch_bus(1'b0, 0, "R11");
    @(posedge clk);
    if (fl || m != mdl_mode) res_q.delete();
    mdl_mode = m;
  endtask

  task automatic idles(input int n);
    for (int i = 0; i < n; i++) idle_cycle(mdl_mode, 1'b0);
  endtask

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  localparam logic [AW-1:0] A = 16'h0040, B = 16'h0A88, C = 16'h0C10, D = 16'h0E18;
  localparam logic [AW-1:0] X = 16'h0100, Y = 16'h0300, Z = 16'h0500;

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R11 reset state
    cmp("R11", "cpu_ready after reset", 64'(cpu_ready), 64'(0));
    cmp("R11", "mem_req after reset", 64'(mem_req), 64'(0));
    @(posedge clk);

    // mixed mode: miss then hit, same line other offset
    lat = 2;
    do_op("R9", 0, 0, A, '0);
    do_op("R2", 0, 0, A, '0);
    do_op("R1", 0, 1, A + 16'd5, '0);

    // write hit updates line; read-back hits
    do_op("R4", 1, 0, A, 64'h1111_2222_3333_4444);
    do_op("R4", 0, 0, A, '0);

    // write miss: no allocate; read waits for drain
    lat = 3;
    do_op("R7", 1, 0, B, 64'hDEAD_BEEF_0000_0001);
    do_op("R7", 0, 0, B, '0);

    // back-to-back stores stall on the single buffer entry
    do_op("R5", 1, 0, C, 64'hAAAA_0000_0000_0001);
    do_op("R5", 1, 0, D, 64'hBBBB_0000_0000_0002);
    idles(6);

    // LRU with invalid-first fill in set 32
    lat = 1;
    do_op("R8", 0, 0, X, '0);
    do_op("R8", 0, 0, Y, '0);
    do_op("R8", 0, 0, X, '0);
    do_op("R8", 0, 0, Z, '0);
    do_op("R8", 0, 0, X, '0);
    do_op("R8", 0, 0, Y, '0);
    do_op("R1", 0, 0, Z, '0);

    // flush drops everything
    idle_cycle(mdl_mode, 1'b1);
    do_op("R10", 0, 0, X, '0);

    // instruction-only mode (mode change also invalidates)
    idle_cycle(2'b00, 1'b0);
    do_op("R10", 0, 1, X, '0);
    do_op("R3", 0, 0, Y, '0);
    do_op("R3", 0, 0, Y, '0);
    do_op("R3", 0, 1, Y, '0);
    do_op("R3", 0, 1, Y, '0);
    do_op("R4", 1, 0, Y, 64'h5555_6666_7777_8888);
    do_op("R4", 0, 1, Y, '0);

    // data-only mode
    idle_cycle(2'b01, 1'b0);
    do_op("R3", 0, 1, A, '0);
    do_op("R3", 0, 1, A, '0);
    do_op("R3", 0, 0, A, '0);
    do_op("R3", 0, 0, A, '0);
    idle_cycle(2'b11, 1'b0);
    do_op("R3", 0, 1, A, '0);
    do_op("R3", 0, 1, A, '0);

    // mixed traffic over a small address pool
    for (int k = 0; k < 400; k++) begin
      int r = $urandom_range(0, 99);
      logic [AW-1:0] a = AW'((($urandom_range(0, 3) * 64) + $urandom_range(0, 2)) * 8
                             + $urandom_range(0, 7));
      lat = $urandom_range(1, 3);
      if (r < 3) idle_cycle(2'($urandom_range(0, 3)), 1'b0);
      else if (r < 5) idle_cycle(mdl_mode, 1'b1);
      else if (r < 35) do_op("R4", 1, 1'($urandom_range(0, 1)), a, {$urandom, $urandom});
      else do_op("R8", 0, 1'($urandom_range(0, 1)), a, '0);
    end

    idles(8);
    cmp("R4", "stores left undrained", 64'(wq.size()), 64'(0));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule